// File: doc/BRIEF.md
# Graphics Aperture Address Translator

This block sits on the path from a graphics port into system memory and remaps 32-bit request addresses. A window of the address space, the aperture, is set by a base address and a size select. Any request whose address falls inside that window is translated page by page through a small, fully associative cache of 20 page mappings. Requests outside the window come out unchanged. Pages are 4 KB. The 12-bit offset within the page always passes through, and the cache tag is the page number counted from the aperture base.

A request that hits returns its translated address on the next cycle. A request that misses sends one fetch for its page-table entry, at the table base plus four times the page index. Lookups then stall until the entry arrives. The returned entry fills one cache slot, and the translated address is delivered on the following cycle. The requester sees `req_ready` drop while a fetch is outstanding, so a deep request queue in front of the block simply holds its next item. An invalidate input drops every mapping at once.

Top module: `gart_xlate`

## Requirements
- R1: After reset, `rsp_valid` and `fetch_valid` are low, `req_ready` is high, and every cache slot is empty, so the first in-window request misses.
- R2: A request is accepted when `req_valid` and `req_ready` are both high. An accepted request whose address lies outside the window produces `rsp_valid` one cycle later, with `rsp_addr` equal to the request address.
- R3: The window covers 4 MB << `cfg_size_sel` bytes starting at `cfg_base`, where 0 selects 4 MB and 6 selects 256 MB. Select values 6 and 7 both mean 256 MB. `cfg_base` is aligned to the window size. An address is inside when base <= address < base + size.
- R4: An accepted in-window request whose page is cached produces `rsp_valid` one cycle later. Its `rsp_addr` is the cached 20-bit frame number in bits 31:12, followed by the request's own offset in bits 11:0.
- R5: An accepted in-window request that misses raises `fetch_valid` for exactly one cycle, one cycle after acceptance. `fetch_addr` = `cfg_tbl_base` + 4 × page index, where the page index is (address − base) >> 12. No response is given in that cycle.
- R6: From the cycle after a miss is accepted until the cycle after its entry returns, `req_ready` is low. Requests presented during that time are ignored and produce no response.
- R7: While a fetch is outstanding, `fill_valid` installs the mapping for the pending page, using frame `fill_data[31:12]` (bits 11:0 are ignored). One cycle later, `rsp_valid` is high with that frame and the pending offset, and `req_ready` is high again.
- R8: A fill goes into the lowest-numbered empty slot whenever an empty slot exists.
- R9: When all 20 slots are full, a fill replaces the slot named by a round-robin pointer. The pointer starts at 0, advances by one only when it is used, and wraps from 19 to 0.
- R10: `inval` empties all 20 slots at the clock edge where it is high. A lookup in that same cycle still sees the old contents. A fill in that same cycle is not kept, although its response is still delivered.
- R11: `fill_valid` while no fetch is outstanding has no effect.
- R12: Any 20 distinct in-window pages can be cached at once, and all of them hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_base | input | 32 | Window base address, aligned to the window size |
| cfg_size_sel | input | 3 | Window size select: 4 MB << value, capped at 256 MB |
| cfg_tbl_base | input | 32 | Base address of the page table |
| inval | input | 1 | Empty all cache slots |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request address |
| req_ready | output | 1 | Request can be accepted this cycle |
| rsp_valid | output | 1 | Result present |
| rsp_addr | output | 32 | Translated or passed-through address |
| fetch_valid | output | 1 | One-cycle table-entry fetch request |
| fetch_addr | output | 32 | Address of the table entry to fetch |
| fill_valid | input | 1 | Table entry returned |
| fill_data | input | 32 | Returned entry; frame number in bits 31:12 |

## Verification
The bench probes the window edges: the last byte below the base, the first byte past the end, and an address that only falls inside after the size select is widened. A wrong compare at any of these would translate an address that should pass through, or pass one through that should be translated. It fills all 20 slots and then keeps missing past the wrap of the round-robin pointer. A victim choice that ignored empty slots, skipped slot 19, or advanced on free fills would evict the wrong page, and a later lookup would then miss or hit where it should not. It drives requests and stray fills during a stall. It also places an invalidate in the same cycle as a fill. A design that leaked a stalled request, took a stray fill, or kept the invalidated fill would give an extra response or a wrong hit afterwards.

// File: rtl/gart_xlate.sv
module gart_xlate #(
  parameter int AW          = 32,
  parameter int ENTRIES     = 20,
  parameter int PAGE_BITS   = 12,
  parameter int MIN_AP_BITS = 22,
  parameter int SIZE_STEPS  = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_base,
  input  logic [2:0]    cfg_size_sel,
  input  logic [AW-1:0] cfg_tbl_base,
  input  logic          inval,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_addr,
  output logic          fetch_valid,
  output logic [AW-1:0] fetch_addr,
  input  logic          fill_valid,
  input  logic [AW-1:0] fill_data
);
  localparam int IDX_W   = MIN_AP_BITS + SIZE_STEPS - 1 - PAGE_BITS;
  localparam int FRAME_W = AW - PAGE_BITS;
  localparam int PTR_W   = $clog2(ENTRIES);

  logic [ENTRIES-1:0]   vld;
  logic [IDX_W-1:0]     tag   [ENTRIES];
  logic [FRAME_W-1:0]   frame [ENTRIES];
  logic [PTR_W-1:0]     rr;
  logic                 waiting;
  logic [IDX_W-1:0]     pend_idx;
  logic [PAGE_BITS-1:0] pend_off;

  logic [2:0]           sel_c;
  logic [AW-1:0]        ap_mask;
  logic                 in_ap;
  logic [IDX_W-1:0]     pg_idx;
  logic                 hit;
  logic [FRAME_W-1:0]   hit_frame;
  logic                 free_any;
  logic [PTR_W-1:0]     free_idx;
  logic [PTR_W-1:0]     victim;
  logic                 accept;
  logic                 do_fill;

  assign sel_c     = (cfg_size_sel > 3'(SIZE_STEPS - 1)) ? 3'(SIZE_STEPS - 1) : cfg_size_sel;
  assign ap_mask   = (AW'(1) << (MIN_AP_BITS + int'(sel_c))) - AW'(1);
  assign in_ap     = ((req_addr ^ cfg_base) & ~ap_mask) == '0;
  assign pg_idx    = IDX_W'((req_addr & ap_mask) >> PAGE_BITS);
  assign req_ready = !waiting;
  assign accept    = req_valid && !waiting;
  assign do_fill   = fill_valid && waiting;
  assign victim    = free_any ? free_idx : rr;

  always_comb begin
    hit       = 1'b0;
    hit_frame = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (vld[i] && tag[i] == pg_idx) begin
        hit       = 1'b1;
        hit_frame = frame[i];
      end
    end
  end

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        free_any = 1'b1;
        free_idx = PTR_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      tag[victim]   <= pend_idx;
      frame[victim] <= fill_data[AW-1:PAGE_BITS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld         <= '0;
      rr          <= '0;
      waiting     <= 1'b0;
      pend_idx    <= '0;
      pend_off    <= '0;
      rsp_valid   <= 1'b0;
      rsp_addr    <= '0;
      fetch_valid <= 1'b0;
      fetch_addr  <= '0;
    end else begin
      rsp_valid   <= 1'b0;
      fetch_valid <= 1'b0;
      if (accept) begin
        if (!in_ap) begin
          rsp_valid <= 1'b1;
          rsp_addr  <= req_addr;
        end else if (hit) begin
          rsp_valid <= 1'b1;
          rsp_addr  <= {hit_frame, req_addr[PAGE_BITS-1:0]};
        end else begin
          waiting     <= 1'b1;
          fetch_valid <= 1'b1;
          fetch_addr  <= cfg_tbl_base + AW'({pg_idx, 2'b00});
          pend_idx    <= pg_idx;
          pend_off    <= req_addr[PAGE_BITS-1:0];
        end
      end
      if (do_fill) begin
        waiting     <= 1'b0;
        rsp_valid   <= 1'b1;
        rsp_addr    <= {fill_data[AW-1:PAGE_BITS], pend_off};
        vld[victim] <= 1'b1;
        if (!free_any)
          rr <= (rr == PTR_W'(ENTRIES - 1)) ? '0 : rr + 1'b1;
      end
      if (inval)
        vld <= '0;
    end
  end
endmodule

// File: rtl/gart_xlate_chk.sv
module gart_xlate_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_valid,
  input logic fetch_valid,
  input logic fill_valid
);
  p_fetch_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |=> !fetch_valid);

  p_no_rsp_on_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> !rsp_valid);

  p_stall_on_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> !req_ready);

  p_quiet_while_stalled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !fill_valid) |=> (!rsp_valid && !req_ready));

  p_fill_answers_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && fill_valid) |=> (rsp_valid && req_ready));

  p_accept_answers_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_valid || fetch_valid));
endmodule

bind gart_xlate gart_xlate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .fetch_valid(fetch_valid), .fill_valid(fill_valid)
);

// File: tb/sim_gart_xlate.sv
module sim_gart_xlate;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h4000_0000;
  localparam logic [31:0] TBL  = 32'h1000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_base = BASE;
  logic [2:0]  cfg_size_sel = 3'd0;
  logic [31:0] cfg_tbl_base = TBL;
  logic        inval = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ready;
  logic        rsp_valid;
  logic [31:0] rsp_addr;
  logic        fetch_valid;
  logic [31:0] fetch_addr;
  logic        fill_valid = 1'b0;
  logic [31:0] fill_data = '0;

  gart_xlate u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  string cur = "R1";

  bit          mv [20];
  logic [31:0] mtag [20];
  logic [19:0] mfr [20];
  int          mrr;
  bit          mwait;
  logic [31:0] pidx;
  logic [11:0] poff;
  bit          e_rv, e_fv;
  logic [31:0] e_ra, e_fa;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mv[i]) mv[i] = 0;
      mrr = 0; mwait = 0; e_rv = 0; e_fv = 0; e_ra = 0; e_fa = 0;
    end else begin
      logic [31:0] size;
      int sel, slot;
      bit found;
      e_rv = 0; e_fv = 0;
      sel = (cfg_size_sel > 6) ? 6 : int'(cfg_size_sel);
      size = 32'h0040_0000 << sel;
      if (req_valid && !mwait) begin
        if (req_addr < cfg_base || req_addr - cfg_base >= size) begin
          e_rv = 1; e_ra = req_addr;
        end else begin
          logic [31:0] idx;
          idx = (req_addr - cfg_base) / 4096;
          found = 0;
          for (int i = 0; i < 20; i++)
            if (mv[i] && mtag[i] == idx) begin found = 1; e_ra = {mfr[i], req_addr[11:0]}; end
          if (found) e_rv = 1;
          else begin
            mwait = 1; e_fv = 1; e_fa = cfg_tbl_base + idx * 4;
            pidx = idx; poff = req_addr[11:0];
          end
        end
      end else if (mwait && fill_valid) begin
        slot = -1;
        for (int i = 0; i < 20; i++) if (!mv[i] && slot < 0) slot = i;
        if (slot < 0) begin slot = mrr; mrr = (mrr + 1) % 20; end
        mv[slot] = 1; mtag[slot] = pidx; mfr[slot] = fill_data[31:12];
        mwait = 0; e_rv = 1; e_ra = {fill_data[31:12], poff};
      end
      if (inval) foreach (mv[i]) mv[i] = 0;
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act %h exp %h (t=%0t)", cur, what, act, exp, $time);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
    chk("rsp_valid", 32'(rsp_valid), 32'(e_rv));
    if (e_rv) chk("rsp_addr", rsp_addr, e_ra);
    chk("fetch_valid", 32'(fetch_valid), 32'(e_fv));
    if (e_fv) chk("fetch_addr", fetch_addr, e_fa);
    chk("req_ready", 32'(req_ready), 32'(!mwait));
  endtask

  function automatic logic [31:0] entry_for(logic [31:0] a);
    logic [31:0] idx;
    idx = (a - cfg_base) >> 12;
    return {20'h80000 ^ idx[19:0], 12'hABC};
  endfunction

  task automatic lookup(logic [31:0] a, int delay, bit inval_on_fill = 0);
    req_valid = 1; req_addr = a;
    tick;
    req_valid = 0;
    if (mwait) begin
      for (int d = 0; d < delay; d++) begin
        req_valid = 1; req_addr = 32'h0000_1000 + 32'(d);
        if (d == 0) begin fill_valid = 0; end
        tick;
      end
      fill_valid = 1; fill_data = entry_for(a); inval = inval_on_fill;
      tick;
      fill_valid = 0; inval = 0; req_valid = 0;
    end
    tick;
  endtask

  initial begin
    repeat (3) tick;
    rst_n = 1;
    cur = "R1"; tick; tick;
    lookup(BASE + 32'h0000_5123, 2);

    cur = "R2";
    lookup(32'h1234_5678, 0);
    lookup(BASE - 1, 0);
    lookup(BASE + 32'h0040_0000, 0);

    cur = "R3";
    cfg_size_sel = 3'd2;
    lookup(BASE + 32'h0080_0010, 1);
    lookup(BASE + 32'h00FF_FFFF, 1);
    cfg_size_sel = 3'd7;
    lookup(BASE + 32'h0FFF_F000, 0);
    lookup(BASE + 32'h1000_0000, 0);
    cfg_size_sel = 3'd0;

    cur = "R4";
    lookup(BASE + 32'h0000_5FFF, 0);
    lookup(BASE + 32'h0000_5000, 0);

    cur = "R11";
    fill_valid = 1; fill_data = 32'hDEAD_B000; tick; fill_valid = 0; tick;
    lookup(BASE + 32'h0000_5444, 0);

    cur = "R10";
    inval = 1; tick; inval = 0; tick;
    lookup(BASE + 32'h0000_5444, 1);
    lookup(BASE + 32'h0000_7000, 0, 1);
    lookup(BASE + 32'h0000_7004, 0);
    inval = 1; tick; inval = 0;

    cur = "R8";
    for (int k = 0; k < 20; k++) lookup(BASE + 32'(k * 37) * 4096 + 32'(k), k % 3);

    cur = "R12";
    for (int k = 0; k < 20; k++) lookup(BASE + 32'(k * 37) * 4096 + 32'h100, 0);

    cur = "R9";
    for (int k = 0; k < 24; k++) lookup(BASE + 32'(900 + k) * 4096, 1);
    for (int k = 0; k < 20; k++) lookup(BASE + 32'(k * 37) * 4096, 0);
    for (int k = 0; k < 24; k++) lookup(BASE + 32'(900 + k) * 4096 + 32'h8, 0);

    cur = "R6";
    lookup(BASE + 32'h003F_F000, 5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog act %0d exp below 100000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule